// File: doc/BRIEF.md
# Bus-Mapped SPI Master Port

This block is a byte-wide SPI master that sits behind a single I/O location of an 8-bit processor bus. The bus front end decodes the address and latches the write data. It then gives this block a one-cycle strobe together with the byte. A strobe that arrives while the port is idle loads the byte into the transmit shifter and starts an exchange at once. The same location, when read, returns the byte that the most recent exchange brought in on MISO.

The serial clock is derived directly from the processor clock. SCK changes level on every processor clock, so one bit takes two clocks and a whole byte always takes exactly sixteen. The port uses SPI mode 0 and sends the most significant bit first. SCK rests low. MOSI rests high between exchanges. A busy output covers the sixteen clocks of an exchange. The received byte is published only once the last bit has been captured.

Top module: `spi_port_master`

## Requirements
- R1: While reset is asserted and after it is released, busy is 0, sck is 0, mosi is 1 and rx_data is 0x00.
- R2: A wr_stb sampled high on a clock edge while busy is 0 makes busy 1 from the next cycle on, for exactly 16 consecutive cycles.
- R3: sck is 0 in the first busy cycle and inverts on every clock while busy, which gives 8 rising edges per exchange. sck is 0 whenever busy is 0.
- R4: mosi presents the transmit byte most significant bit first. Bit 7-k is driven during busy cycles 2k and 2k+1, so mosi holds steady while sck is high. mosi is 1 whenever busy is 0.
- R5: miso is sampled on each clock edge where sck goes from 0 to 1. The first sample becomes bit 7 of the received byte and the eighth becomes bit 0.
- R6: rx_data changes only on the edge where busy returns to 0. At that edge it takes the 8 bits just received, and it keeps that value until the next exchange completes.
- R7: A wr_stb sampled while busy is 1, including the last busy cycle, is ignored. The ongoing bit stream, the exchange length and the idle state that follows are all unchanged.
- R8: Writing 0x55 produces mosi = 0,1,0,1,0,1,0,1 over the 8 bit periods, with each level held for 2 clocks.
- R9: A wr_stb in the first cycle after busy falls is accepted, so exchanges can follow one another with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; SCK toggles once per period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle strobe: write data for the port has been latched |
| wr_data | input | DATA_W | Byte to transmit |
| miso | input | 1 | Serial data from the card |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the card, idles high |
| rx_data | output | DATA_W | Last complete received byte, returned on a port read |
| busy | output | 1 | High during the 2*DATA_W clocks of an exchange |

## Verification
The bench builds the port with its defaults: an 8-bit word, MOSI resting high and a two-stage reset synchronizer. This makes each exchange exactly sixteen clocks long, so every bit can be traced cycle by cycle against an independent slave model. The directed scenarios cover the alternating 0x55 pattern, distinct slave replies and a strobe both in the middle and in the very last busy cycle. They also cover back-to-back exchanges separated by a single idle cycle, which reaches the handoff between the end of one exchange and the acceptance of the next.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

  // Level of the serial clock inside one bit period
  typedef enum logic {
    SCK_PH_LOW  = 1'b0,
    SCK_PH_HIGH = 1'b1
  } sck_phase_e;

  // Counter width needed for 2*w clock states
  function automatic int unsigned phase_cnt_w(input int unsigned w);
    return (w < 2) ? 1 : $clog2(2 * w);
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
`timescale 1ns/1ps
module spi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/spi_bit_timer.sv
`timescale 1ns/1ps
module spi_bit_timer
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sck,
  output logic sample_en,
  output logic shift_en,
  output logic done
);

  localparam int unsigned CNT_W = phase_cnt_w(DATA_W);
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(2 * DATA_W - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  sck_phase_e       ph_q, ph_d;
  logic             upd_en;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    upd_en = 1'b0;
    if (start && !busy_q) begin
      upd_en = 1'b1;
      busy_d = 1'b1;
      cnt_d  = '0;
      ph_d   = SCK_PH_LOW;
    end else if (busy_q) begin
      upd_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST_PH) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        ph_d   = SCK_PH_LOW;
      end else begin
        ph_d = (ph_q == SCK_PH_LOW) ? SCK_PH_HIGH : SCK_PH_LOW;
      end
    end
  end

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ph_q   <= SCK_PH_LOW;
    end else if (upd_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
    end
  end

  assign busy      = busy_q;
  assign sck       = (ph_q == SCK_PH_HIGH);
  assign sample_en = busy_q && (ph_q == SCK_PH_LOW);
  assign done      = busy_q && (cnt_q == LAST_PH);
  assign shift_en  = busy_q && (ph_q == SCK_PH_HIGH) && (cnt_q != LAST_PH);

endmodule

// File: rtl/spi_tx_shifter.sv
`timescale 1ns/1ps
module spi_tx_shifter #(
  parameter int unsigned DATA_W    = 8,
  parameter logic        MOSI_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              active,
  output logic              mosi
);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic              sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (load) begin
      sr_d  = load_data;
      sr_en = 1'b1;
    end else if (shift_en) begin
      sr_d  = {sr_q[DATA_W-2:0], 1'b0};
      sr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign mosi = active ? sr_q[DATA_W-1] : MOSI_IDLE;

endmodule

// File: rtl/spi_rx_shifter.sv
`timescale 1ns/1ps
module spi_rx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              miso,
  input  logic              commit,
  output logic [DATA_W-1:0] rx_data
);

  logic [DATA_W-1:0] sr_q, sr_d;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    sr_d = {sr_q[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr_q <= '0;
    else if (sample_en) sr_q <= sr_d;
  end

  // Publish only after the final bit is in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (commit) hold_q <= sr_q;
  end

  assign rx_data = hold_q;

endmodule

// File: rtl/spi_port_master.sv
`timescale 1ns/1ps
module spi_port_master #(
  parameter int unsigned DATA_W      = 8,
  parameter logic        MOSI_IDLE   = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy
);

  logic rst_core_n;
  logic accept;
  logic sample_en;
  logic shift_en;
  logic done;

  spi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign accept = wr_stb && !busy;

  spi_bit_timer #(.DATA_W(DATA_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (wr_stb),
    .busy      (busy),
    .sck       (sck),
    .sample_en (sample_en),
    .shift_en  (shift_en),
    .done      (done)
  );

  spi_tx_shifter #(.DATA_W(DATA_W), .MOSI_IDLE(MOSI_IDLE)) u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (accept),
    .load_data (wr_data),
    .shift_en  (shift_en),
    .active    (busy),
    .mosi      (mosi)
  );

  spi_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sample_en (sample_en),
    .miso      (miso),
    .commit    (done),
    .rx_data   (rx_data)
  );

endmodule

// File: rtl/spi_port_master_chk.sv
`timescale 1ns/1ps
module spi_port_master_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter logic        MOSI_IDLE = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              sck,
  input logic              mosi,
  input logic              busy,
  input logic [DATA_W-1:0] rx_data
);

  localparam int unsigned RUN_W = $clog2(2 * DATA_W + 2);
  localparam logic [RUN_W-1:0] FRAME = RUN_W'(2 * DATA_W);

  logic             seen_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!busy)          run_q <= '0;
    else if (run_q <= FRAME) run_q <= run_q + 1'b1;
  end

  assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_mosi_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mosi == MOSI_IDLE));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy) |=> (busy && !sck));

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !busy && $past(busy)) |-> (run_q == FRAME));

  assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= FRAME);

  assert_sck_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && busy && $past(busy)) |-> (sck != $past(sck)));

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && busy && sck) |-> (mosi == $past(mosi)));

  assert_rx_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (rx_data != $past(rx_data))) |-> ($past(busy) && !busy));

endmodule

bind spi_port_master spi_port_master_chk #(.DATA_W(DATA_W), .MOSI_IDLE(MOSI_IDLE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .wr_stb  (wr_stb),
  .sck     (sck),
  .mosi    (mosi),
  .busy    (busy),
  .rx_data (rx_data)
);

// File: tb/spi_port_master_test.sv
`timescale 1ns/1ps
module spi_port_master_test;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       miso;
  logic       sck;
  logic       mosi;
  logic [7:0] rx_data;
  logic       busy;

  int total;
  int bad;
  logic [7:0] prev_rx;

  spi_port_master uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .rx_data (rx_data),
    .busy    (busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = 8'h00;
    miso    = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(sck == 1'b0, "R1 sck in reset", sck, 0);
    chk(mosi == 1'b1, "R1 mosi in reset", mosi, 1);
    chk(rx_data == 8'h00, "R1 rx in reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && sck == 1'b0 && mosi == 1'b1 && rx_data == 8'h00,
        "R1 after release", {busy, sck, mosi}, 3'b001);
    prev_rx = 8'h00;
  endtask

  // Called at a negedge; drives a strobe now and follows the whole exchange.
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sl,
                          input int poke_at, input logic [7:0] poke_val,
                          input string mtag);
    wr_stb  = 1'b1;
    wr_data = tx;
    @(negedge clk);
    wr_stb = 1'b0;
    for (int j = 0; j < 16; j++) begin
      chk(busy == 1'b1, "R2 busy during exchange", busy, 1);
      chk(sck == logic'(j % 2), "R3 sck phase", sck, j % 2);
      chk(mosi == tx[7 - j/2], mtag, mosi, tx[7 - j/2]);
      chk(rx_data == prev_rx, "R6 rx stable mid exchange", rx_data, prev_rx);
      miso = sl[7 - j/2];
      if (j == poke_at) begin
        wr_stb  = 1'b1;
        wr_data = poke_val;
      end else begin
        wr_stb = 1'b0;
      end
      @(negedge clk);
    end
    wr_stb = 1'b0;
    chk(busy == 1'b0, "R2 busy ends after 16", busy, 0);
    chk(sck == 1'b0, "R3 sck idle", sck, 0);
    chk(mosi == 1'b1, "R4 mosi idle", mosi, 1);
    chk(rx_data == sl, "R5 received byte", rx_data, sl);
    prev_rx = sl;
  endtask

  task automatic t_basic();
    @(negedge clk);
    run_xfer(8'hA5, 8'h3C, -1, 8'h00, "R4 msb first A5");
    @(negedge clk);
    run_xfer(8'h81, 8'hE7, -1, 8'h00, "R4 msb first 81");
  endtask

  task automatic t_pattern55();
    @(negedge clk);
    run_xfer(8'h55, 8'hC3, -1, 8'h00, "R8 alternating 55");
  endtask

  task automatic t_write_busy();
    @(negedge clk);
    run_xfer(8'h0F, 8'h96, 5, 8'hF0, "R7 mid strobe ignored");
    chk(busy == 1'b0, "R7 no restart after mid strobe", busy, 0);
    @(negedge clk);
    run_xfer(8'h3C, 8'h5A, 15, 8'hFF, "R7 last-cycle strobe ignored");
    @(negedge clk);
    chk(busy == 1'b0, "R7 no restart after last-cycle strobe", busy, 0);
    chk(mosi == 1'b1 && sck == 1'b0, "R7 idle kept", {sck, mosi}, 2'b01);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    run_xfer(8'hC6, 8'h11, -1, 8'h00, "R9 first of pair");
    run_xfer(8'h29, 8'hEE, -1, 8'h00, "R9 second accepted at once");
  endtask

  task automatic t_idle_hold();
    for (int k = 0; k < 10; k++) begin
      miso = logic'(k % 2);
      @(negedge clk);
      chk(rx_data == prev_rx && busy == 1'b0 && sck == 1'b0,
          "R6 rx held while idle", rx_data, prev_rx);
    end
  endtask

  initial begin
    total = 0;
    bad   = 0;
    t_reset();
    t_basic();
    t_pattern55();
    t_write_busy();
    t_back_to_back();
    t_idle_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule